// File: doc/BRIEF.md
# Serial Frame Receiver with Silence Timeout

This block takes bytes from a UART receiver and collects them into a frame buffer. No byte carries a start or end marker. The end of a frame is found only from silence on the line. Every byte the block accepts restarts a one-shot timer, whether the byte is good or bad. The timer counts whole microseconds from a prescaled system clock. When it runs out, the frame is closed. A consumer is then given a one-cycle `frame_valid` pulse, the frame length and a two-bit error status.

The length of the silence depends on the baud rate. At 19200 baud and below it is one and a half character times, with a character taken as 11 bits. Above 19200 baud it is fixed at 750 microseconds.

A byte that arrives with a line error is not stored. It taints the whole frame. A byte that arrives when the buffer is already full is dropped and also taints the frame, with its own code. After a frame is closed the block ignores the line until the consumer re-arms it. While the frame is held, the consumer reads the stored bytes through a registered address/data port.

Top module: `rtu_frame_rx`

## Requirements
- R1: After reset the block is receiving. `frame_valid` is 0, `frame_len` is 0 and `frame_err` is 0 (no error).
- R2: A byte with `rx_valid`=1 and `rx_err`=0, taken while receiving into a buffer that is not full, is stored at index `frame_len` and `frame_len` then rises by one. `rd_data` shows the byte at `rd_addr` one clock after the address is applied.
- R3: The timeout is `TIMEOUT_US` = 16500000/BAUD (integer division) when BAUD <= 19200, and 750 otherwise. `frame_valid` rises exactly `TIMEOUT_US*CLK_MHZ` clock edges after the edge that took the last byte. Each byte taken restarts this count. A byte taken on the same edge where the count would run out continues the frame.
- R4: A byte taken with `rx_err`=1 is not stored and leaves `frame_len` unchanged. It sets `frame_err` to 1 (line error) and restarts the timer.
- R5: A good byte taken when `frame_len` equals DEPTH is not stored. `frame_len` stays at DEPTH and `frame_err` becomes 2 (frame too long).
- R6: Error codes are 0 = none, 1 = line error and 2 = too long. When a frame has more than one faulting byte, `frame_err` holds the code of the most recent one.
- R7: `frame_valid` is high for exactly one cycle per frame. `frame_len` and `frame_err` keep their values while the frame is held.
- R8: While a frame is held, incoming bytes are ignored. The length, the error code and the buffer contents do not change, and no further `frame_valid` pulse is produced.
- R9: `rearm` clears the length and the error code, returns the block to receiving and stops the timer. A byte presented on the same edge as `rearm` is dropped.
- R10: No frame is produced unless at least one byte has been taken since reset or the last `rearm`, however long the line stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_MHZ megahertz |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a byte has arrived from the UART |
| rx_data | input | 8 | Byte value |
| rx_err | input | 1 | The byte had a framing, overrun or noise error |
| rearm | input | 1 | Discard the held frame and start receiving |
| rd_addr | input | ADDR_W | Buffer read index |
| frame_valid | output | 1 | One-cycle pulse: a frame has been closed |
| frame_len | output | LEN_W | Number of bytes stored |
| frame_err | output | 2 | 0 none, 1 line error, 2 too long |
| rd_data | output | 8 | Buffer byte at the previous cycle's rd_addr |

## Verification
The bench drives each byte on a falling edge, so the byte is taken on the next rising edge. From that edge it counts exactly `TIMEOUT_US*CLK_MHZ-1` falling edges and checks that `frame_valid` is still low. It then checks one edge later that the pulse is present. This pins the closing cycle of the frame exactly, for two baud-rate settings at once. Length and error are sampled in the cycle after the pulse. Buffer bytes are read one falling edge after the address is set, which matches the single register in the read path. Ignored and dropped bytes are checked through the length, the error code, a running count of pulses and a read-back of the buffer.

// File: rtl/rtu_rx_pkg.sv
package rtu_rx_pkg;

    typedef enum logic {
        ST_RECV = 1'b0,
        ST_HOLD = 1'b1
    } rtu_st_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_LINE = 2'd1,
        ERR_LONG = 2'd2
    } rtu_err_e;

    // silence length in microseconds for a given baud rate
    function automatic int silence_us(input int baud);
        if (baud <= 19200)
            return (1000000 * 11 * 3 / 2) / baud;
        else
            return 750;
    endfunction

endpackage

// File: rtl/rtu_us_tick.sv
module rtu_us_tick #(
    parameter int CLK_MHZ = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;

    logic [PW-1:0] div_d, div_q;

    assign tick = (div_q == PW'(CLK_MHZ - 1));

    always_comb begin
        if (clr || tick)
            div_d = '0;
        else
            div_d = div_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/rtu_silence_timer.sv
module rtu_silence_timer #(
    parameter int TIMEOUT_US = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic stop,
    input  logic tick,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT_US + 1);

    typedef struct packed {
        logic          run;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    assign expired = q.run && tick && (q.cnt == TW'(TIMEOUT_US - 1));

    always_comb begin
        d = q;
        if (stop) begin
            d.run = 1'b0;
            d.cnt = '0;
        end else if (restart) begin
            d.run = 1'b1;
            d.cnt = '0;
        end else if (expired) begin
            d.run = 1'b0;
        end else if (q.run && tick) begin
            d.cnt = q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_NO_EARLY_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !expired); // R3
    AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !expired); // R9
endmodule

// File: rtl/rtu_frame_buf.sv
module rtu_frame_buf #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_d, rd_q;

    assign rd_d    = mem[rd_addr];
    assign rd_data = rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end
endmodule

// File: rtl/rtu_frame_rx.sv
module rtu_frame_rx
    import rtu_rx_pkg::*;
#(
    parameter int  CLK_MHZ = 50,
    parameter int  BAUD    = 19200,
    parameter int  DEPTH   = 256,
    localparam int LEN_W   = $clog2(DEPTH + 1),
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_err,
    input  logic              rearm,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              frame_valid,
    output logic [LEN_W-1:0]  frame_len,
    output logic [1:0]        frame_err,
    output logic [7:0]        rd_data
);
    localparam int TIMEOUT_US = silence_us(BAUD);

    typedef struct packed {
        rtu_st_e          st;
        logic [LEN_W-1:0] cnt;
        rtu_err_e         err;
        logic             fv;
    } ctl_t;

    ctl_t d, q;
    logic tick, tmr_expired, byte_take, wr_en;

    rtu_us_tick #(.CLK_MHZ(CLK_MHZ)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (byte_take | rearm),
        .tick  (tick)
    );

    rtu_silence_timer #(.TIMEOUT_US(TIMEOUT_US)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (byte_take),
        .stop    (rearm),
        .tick    (tick),
        .expired (tmr_expired)
    );

    rtu_frame_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (q.cnt[ADDR_W-1:0]),
        .wr_data (rx_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_comb begin
        d         = q;
        d.fv      = 1'b0;
        byte_take = 1'b0;
        wr_en     = 1'b0;
        if (rearm) begin
            d.st  = ST_RECV;
            d.cnt = '0;
            d.err = ERR_NONE;
        end else if (q.st == ST_RECV) begin
            if (rx_valid) begin
                // a byte on the expiry edge keeps the frame open
                byte_take = 1'b1;
                if (rx_err) begin
                    d.err = ERR_LINE;
                end else if (q.cnt == LEN_W'(DEPTH)) begin
                    d.err = ERR_LONG;
                end else begin
                    wr_en = 1'b1;
                    d.cnt = q.cnt + LEN_W'(1);
                end
            end else if (tmr_expired) begin
                d.st = ST_HOLD;
                d.fv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_RECV;
            q.cnt <= '0;
            q.err <= ERR_NONE;
            q.fv  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign frame_valid = q.fv;
    assign frame_len   = q.cnt;
    assign frame_err   = q.err;

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LEN_W'(DEPTH)); // R5
    AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !rearm |=> (q.cnt == $past(q.cnt)) || (q.cnt == $past(q.cnt) + LEN_W'(1))); // R2
    AST_FV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid); // R7
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD && !rearm) |=> $stable(frame_len) && $stable(frame_err) && !frame_valid); // R8
    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (frame_len == '0) && (frame_err == 2'd0) && !frame_valid); // R9
    AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err != 2'd3); // R6
endmodule

// File: tb/rtu_frame_rx_tb_top.sv
module rtu_frame_rx_tb_top;
    localparam int CLK_MHZ = 2;
    localparam int DEPTH   = 8;
    localparam int LEN_W   = $clog2(DEPTH + 1);
    localparam int ADDR_W  = $clog2(DEPTH);

    function automatic int exp_timeout_us(input int baud);
        if (baud <= 19200) return 16500000 / baud;
        return 750;
    endfunction

    localparam int TC_SLOW = exp_timeout_us(19200) * CLK_MHZ;
    localparam int TC_FAST = exp_timeout_us(115200) * CLK_MHZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_err = 1'b0;
    logic rearm = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic frame_valid, fast_fv;
    logic [LEN_W-1:0] frame_len, fast_len;
    logic [1:0] frame_err, fast_err;
    logic [7:0] rd_data, fast_rd;

    always #10 clk = ~clk;

    rtu_frame_rx #(.CLK_MHZ(CLK_MHZ), .BAUD(19200), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .rearm(rearm), .rd_addr(rd_addr),
        .frame_valid(frame_valid), .frame_len(frame_len),
        .frame_err(frame_err), .rd_data(rd_data));

    rtu_frame_rx #(.CLK_MHZ(CLK_MHZ), .BAUD(115200), .DEPTH(DEPTH)) dut_fast_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .rearm(rearm), .rd_addr(rd_addr),
        .frame_valid(fast_fv), .frame_len(fast_len),
        .frame_err(fast_err), .rd_data(fast_rd));

    int n_checks = 0;
    int n_fail = 0;
    int fv_seen = 0;
    int frames_exp = 0;
    logic [7:0] em [DEPTH];
    int ecnt = 0;
    int eerr = 0;
    bit ehold = 0;

    always @(negedge clk) if (rst_n && frame_valid) fv_seen++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] dat, input bit bad, input int gap);
        rx_valid = 1'b1; rx_data = dat; rx_err = bad;
        if (!ehold) begin
            if (bad) eerr = 1;
            else if (ecnt == DEPTH) eerr = 2;
            else begin em[ecnt] = dat; ecnt++; end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_err = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_rearm();
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
        ecnt = 0; eerr = 0; ehold = 0;
    endtask

    task automatic readback(input string req);
        for (int i = 0; i < ecnt; i++) begin
            rd_addr = ADDR_W'(i);
            @(negedge clk);
            chk(rd_data == em[i], req, "buffer byte", int'(rd_data), int'(em[i]));
        end
    endtask

    // called at the falling edge right after the last byte was taken
    task automatic close_frame(input string req);
        repeat (TC_SLOW - 1) @(negedge clk);
        chk(frame_valid == 1'b0, "R3", "valid before timeout", int'(frame_valid), 0);
        @(negedge clk);
        chk(frame_valid == 1'b1, "R3", "valid at timeout", int'(frame_valid), 1);
        ehold = 1; frames_exp++;
        chk(int'(frame_len) == ecnt, req, "frame length", int'(frame_len), ecnt);
        chk(int'(frame_err) == eerr, req, "frame error", int'(frame_err), eerr);
        @(negedge clk);
        chk(frame_valid == 1'b0, "R7", "valid one cycle", int'(frame_valid), 0);
        chk(int'(frame_len) == ecnt, "R7", "length held", int'(frame_len), ecnt);
        readback(req);
        chk(fv_seen == frames_exp, "R7", "pulse count", fv_seen, frames_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(frame_valid == 1'b0, "R1", "valid after reset", int'(frame_valid), 0);
        chk(frame_len == '0, "R1", "length after reset", int'(frame_len), 0);
        chk(frame_err == 2'd0, "R1", "error after reset", int'(frame_err), 0);

        // R3 both baud settings from one byte
        send_byte(8'hA5, 1'b0, 0);
        repeat (TC_FAST - 1) @(negedge clk);
        chk(fast_fv == 1'b0, "R3", "fast valid early", int'(fast_fv), 0);
        @(negedge clk);
        chk(fast_fv == 1'b1, "R3", "fast valid at 750us", int'(fast_fv), 1);
        repeat (TC_SLOW - 1 - TC_FAST) @(negedge clk);
        chk(frame_valid == 1'b0, "R3", "slow valid early", int'(frame_valid), 0);
        @(negedge clk);
        chk(frame_valid == 1'b1, "R3", "slow valid at 1.5 char", int'(frame_valid), 1);
        ehold = 1; frames_exp++;
        @(negedge clk);
        chk(int'(frame_len) == 1, "R2", "single byte length", int'(frame_len), 1);
        readback("R2");
        do_rearm();

        // R10 idle line produces nothing
        repeat (2 * TC_SLOW + 20) @(negedge clk);
        chk(fv_seen == frames_exp, "R10", "no frame on idle line", fv_seen, frames_exp);

        // R3 restart: gaps just under and exactly at the timeout
        send_byte(8'h11, 1'b0, TC_SLOW - 2);
        send_byte(8'h22, 1'b0, TC_SLOW - 1);
        send_byte(8'h33, 1'b0, 0);
        close_frame("R3");
        do_rearm();

        // R4 line error inside a frame
        send_byte(8'h01, 1'b0, 3);
        send_byte(8'hEE, 1'b1, 0);
        send_byte(8'h02, 1'b0, 0);
        close_frame("R4");
        do_rearm();

        // R5 overflow
        for (int i = 0; i < DEPTH + 2; i++) send_byte(8'(8'h40 + i), 1'b0, 0);
        close_frame("R5");
        do_rearm();

        // R6 overflow then line error: last fault wins
        for (int i = 0; i < DEPTH + 1; i++) send_byte(8'(8'h60 + i), 1'b0, 0);
        send_byte(8'h99, 1'b1, 0);
        close_frame("R6");
        do_rearm();
        send_byte(8'h98, 1'b1, 1);
        for (int i = 0; i < DEPTH + 1; i++) send_byte(8'(8'h70 + i), 1'b0, 0);
        close_frame("R6");

        // R8 bytes ignored while held
        send_byte(8'hC3, 1'b0, 0);
        send_byte(8'hC4, 1'b1, 5);
        repeat (TC_SLOW + 10) @(negedge clk);
        chk(int'(frame_len) == ecnt, "R8", "length while held", int'(frame_len), ecnt);
        chk(int'(frame_err) == eerr, "R8", "error while held", int'(frame_err), eerr);
        chk(fv_seen == frames_exp, "R8", "no pulse while held", fv_seen, frames_exp);
        readback("R8");

        // R9 rearm with a byte on the same edge: byte dropped, no frame
        rx_valid = 1'b1; rx_data = 8'h5A;
        do_rearm();
        rx_valid = 1'b0;
        chk(frame_len == '0, "R9", "length after rearm", int'(frame_len), 0);
        chk(frame_err == 2'd0, "R9", "error after rearm", int'(frame_err), 0);
        repeat (TC_SLOW + 10) @(negedge clk);
        chk(fv_seen == frames_exp, "R9", "dropped byte makes no frame", fv_seen, frames_exp);

        // R9 rearm mid-frame discards the partial bytes
        send_byte(8'h10, 1'b0, 2);
        send_byte(8'h20, 1'b0, 2);
        do_rearm();
        send_byte(8'h30, 1'b0, 4);
        send_byte(8'h40, 1'b0, 0);
        close_frame("R9");
        do_rearm();

        // random frames
        for (int f = 0; f < 10; f++) begin
            int len;
            len = 1 + int'($urandom_range(DEPTH + 2));
            for (int b = 0; b < len; b++) begin
                bit bad;
                bad = ($urandom_range(5) == 0);
                send_byte(8'($urandom), bad,
                          (b == len - 1) ? 0 : int'($urandom_range(300)));
            end
            close_frame("R2");
            do_rearm();
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule